// File: doc/BRIEF.md
# Prioritised Edge/Level Interrupt Controller

This block gathers 32 interrupt request lines into two processor-facing outputs, a normal interrupt (`irq_out`) and a fast interrupt (`fiq_out`). Each line carries its own configuration: a 5-bit priority, a sensitivity choice (edge or level), and a steering bit that picks which output it feeds. Input activity is captured in a pending register. A mask register gates which pending lines may compete. Software reaches all of this through a word-wide register port.

Each output has a small two-state agreement machine. In `AG_OPEN`, the output is low and the machine waits. The transition `OPEN->HELD` is taken as soon as any unmasked pending line is steered to that channel. On that transition the arbiter's winner is latched as the channel's source code, and the output goes high. In `AG_HELD`, the output stays high and the code is frozen. The transition `HELD->OPEN` is taken only when software writes the matching new-agreement bit of the control register.

Reading a source code returns the latched line number. If that line is edge-sensitive, the read also clears its pending bit, which acknowledges the source. Software can also inject an interrupt: writing a word to the software-interrupt register behaves as an assertion of the lowest line whose bit is set in that word.

Top module: `edge_level_intc`

## Requirements
- R1: After reset, the mask register (0x04) reads 0xFFFFFFFF, the pending register (0x00) and every line configuration read 0, and both outputs are low.
- R2: Line n's configuration lives at offset 0x1C+4n. Its fields are priority in bits [6:2], sensitivity in bit 1 (1 = level, 0 = edge) and steering in bit 0 (1 = fast channel). It reads back those 7 bits only, and bits above 6 are dropped on write.
- R3: On an edge line, a rising input sets pending only if the input was low before and pending was clear. The bit survives deassertion of the input. A bit cleared while the input stays high is not set again.
- R4: On a level line, a rising input sets pending and a falling input clears it.
- R5: A write to offset 0x00 ANDs the pending register with the written word. Bits of level lines whose input is high are kept.
- R6: Among unmasked pending lines steered to a channel, the lowest priority value wins. On a tie, the highest line number wins. Lines steered to the other channel, and masked lines, do not compete.
- R7: A channel output rises once a competing line exists and stays high until its new-agreement bit is written (control offset 0x18, bit 0 for the normal channel, bit 1 for the fast channel). After that write the output is low for at least one cycle before it re-evaluates. The control register reads as 0.
- R8: A read of 0x10 (normal) or 0x14 (fast) returns the line number latched at the last `OPEN->HELD` transition. It clears that line's pending bit if the line is edge-sensitive and leaves it unchanged if the line is level-sensitive.
- R9: A write to 0x9C asserts only the lowest set bit's line, as an input assertion would. The register reads as 0.
- R10: Undefined offsets read 0 and ignore writes. Writes to 0x10 and 0x14 have no effect.
- R11: Changing the mask re-evaluates both channels: unmasking a pending line raises its channel output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lines | input | 32 | Interrupt request inputs, active high |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (source-code reads have side effects) |
| reg_addr | input | 8 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the cycle `reg_rd` is high, 0 otherwise |
| irq_out | output | 1 | Normal-channel interrupt output |
| fiq_out | output | 1 | Fast-channel interrupt output |

## Verification
The bench targets the following corner cases. Arbitration ties must go to the highest line number; a design that scans the other way returns the lower line as the code. The acknowledge-by-read must clear only edge lines; a design that clears level lines too would lose an active level source. A pending write must not clear a level line whose input is high; a design that masks blindly drops a live request. An edge line cleared while its input is held high must stay clear; a design that samples levels instead of transitions would re-raise it. Software injection of several bits must take only the lowest, and writes to read-only or undefined offsets must leave the mask untouched.

// File: rtl/intc_pkg.sv
package intc_pkg;

    // Per-channel agreement state
    typedef enum logic {
        AG_OPEN = 1'b0,
        AG_HELD = 1'b1
    } agr_state_t;

    // Channel indices
    localparam int CH_NORM = 0;
    localparam int CH_FAST = 1;

    // Line configuration word field positions
    localparam int CFG_STEER_BIT = 0;
    localparam int CFG_SENS_BIT  = 1;
    localparam int CFG_PRIO_LSB  = 2;

endpackage

// File: rtl/intc_arbiter.sv
module intc_arbiter #(
    parameter int NLINES = 32,
    parameter int PRIO_W = 5,
    localparam int IDX_W = $clog2(NLINES)
) (
    input  logic [NLINES-1:0]             req,
    input  logic [NLINES-1:0][PRIO_W-1:0] prio,
    output logic                          any,
    output logic [IDX_W-1:0]              win
);

    logic [PRIO_W-1:0] best;

    // Ascending scan with <= : ties resolve to the highest line number
    always_comb begin
        any  = 1'b0;
        best = '1;
        win  = '0;
        for (int i = 0; i < NLINES; i++) begin
            if (req[i] && (!any || prio[i] <= best)) begin
                any  = 1'b1;
                best = prio[i];
                win  = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/intc_agree_fsm.sv
module intc_agree_fsm
    import intc_pkg::*;
#(
    parameter int NLINES = 32,
    parameter int PRIO_W = 5,
    localparam int IDX_W = $clog2(NLINES)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NLINES-1:0]             req,
    input  logic [NLINES-1:0][PRIO_W-1:0] prio,
    input  logic                          strobe,
    output logic                          out,
    output logic [IDX_W-1:0]              code
);

    agr_state_t        state, nxt;
    logic              any_req;
    logic [IDX_W-1:0]  win;

    intc_arbiter #(.NLINES(NLINES), .PRIO_W(PRIO_W)) u_arb (
        .req  (req),
        .prio (prio),
        .any  (any_req),
        .win  (win)
    );

    always_comb begin
        nxt = state;
        unique case (state)
            AG_OPEN: if (any_req) nxt = AG_HELD;
            AG_HELD: if (strobe)  nxt = AG_OPEN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= AG_OPEN;
            code  <= '0;
        end else begin
            state <= nxt;
            if (state == AG_OPEN && any_req)
                code <= win;
        end
    end

    always_comb out = (state == AG_HELD);

    AST_STROBE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && state == AG_HELD) |=> !out); // R7
    AST_NO_SPUR: assert property (@(posedge clk) disable iff (!rst_n)
        (state == AG_OPEN && !any_req) |=> !out); // R7

endmodule

// File: rtl/intc_line_state.sv
module intc_line_state #(
    parameter int NLINES = 32,
    parameter int PRIO_W = 5,
    localparam int IDX_W = $clog2(NLINES)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NLINES-1:0]             pins,
    input  logic                          cfg_we,
    input  logic [IDX_W-1:0]              cfg_idx,
    input  logic [PRIO_W-1:0]             cfg_prio,
    input  logic                          cfg_sens,
    input  logic                          cfg_steer,
    input  logic                          mask_we,
    input  logic                          pend_we,
    input  logic [NLINES-1:0]             wdata,
    input  logic [NLINES-1:0]             swi_ev,
    input  logic [NLINES-1:0]             ack_clr,
    output logic [NLINES-1:0]             pend_q,
    output logic [NLINES-1:0]             mask_q,
    output logic [NLINES-1:0]             sens_q,
    output logic [NLINES-1:0]             steer_q,
    output logic [NLINES-1:0][PRIO_W-1:0] prio_q
);

    logic [NLINES-1:0] pin_q, live_q;
    logic [NLINES-1:0] up_ev, down_ev, pend_nx;

    always_comb begin
        up_ev   = (pins & ~pin_q) | swi_ev;
        down_ev = ~pins & pin_q & ~up_ev;
        pend_nx = pend_q;
        if (pend_we)
            pend_nx = pend_nx & (wdata | (live_q & sens_q));
        pend_nx = pend_nx & ~ack_clr;
        pend_nx = pend_nx & ~(down_ev & sens_q);
        pend_nx = pend_nx | (up_ev & (sens_q | ~live_q));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_q   <= '0;
            live_q  <= '0;
            pend_q  <= '0;
            mask_q  <= '1;
            sens_q  <= '0;
            steer_q <= '0;
            prio_q  <= '0;
        end else begin
            pin_q  <= pins;
            live_q <= (live_q | up_ev) & ~down_ev;
            pend_q <= pend_nx;
            if (mask_we)
                mask_q <= wdata;
            if (cfg_we) begin
                prio_q[cfg_idx]  <= cfg_prio;
                sens_q[cfg_idx]  <= cfg_sens;
                steer_q[cfg_idx] <= cfg_steer;
            end
        end
    end

    AST_LEVEL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (|(down_ev & sens_q)) |=> ((pend_q & $past(down_ev & sens_q)) == '0)); // R4
    AST_EDGE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !pend_we |=> (($past(pend_q & ~sens_q & ~ack_clr) & ~pend_q) == '0)); // R3

endmodule

// File: rtl/edge_level_intc.sv
module edge_level_intc
    import intc_pkg::*;
#(
    parameter int NLINES = 32,
    parameter int PRIO_W = 5,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       irq_lines,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [7:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq_out,
    output logic              fiq_out
);

    localparam int IDX_W    = $clog2(NLINES);
    localparam int A_PEND   = 'h00;
    localparam int A_MASK   = 'h04;
    localparam int A_NCODE  = 'h10;
    localparam int A_FCODE  = 'h14;
    localparam int A_CTRL   = 'h18;
    localparam int A_CFG0   = 'h1C;
    localparam int A_CFGN   = A_CFG0 + 4 * (NLINES - 1);
    localparam int A_SWI    = A_CFGN + 4;
    localparam int CFG_W    = PRIO_W + CFG_PRIO_LSB;

    logic [NLINES-1:0]             pend_q, mask_q, sens_q, steer_q;
    logic [NLINES-1:0][PRIO_W-1:0] prio_q;
    logic [NLINES-1:0]             swi_ev, ack_clr;
    logic [NLINES-1:0]             chan_req [2];
    logic [1:0]                    strobe, chan_out;
    logic [IDX_W-1:0]              chan_code [2];
    logic [ADDR_W-1:0]             cfg_off;
    logic [IDX_W-1:0]              cfg_idx;
    logic                          cfg_hit, aligned;
    logic [NLINES-1:0]             wlo;

    always_comb begin
        aligned = (reg_addr[1:0] == 2'b00);
        cfg_hit = aligned && (int'(reg_addr) >= A_CFG0) && (int'(reg_addr) <= A_CFGN);
        cfg_off = reg_addr - ADDR_W'(A_CFG0);
        cfg_idx = cfg_off[IDX_W+1:2];
        wlo     = reg_wdata[NLINES-1:0];
    end

    // Software injection: lowest set bit only
    always_comb begin
        swi_ev = '0;
        if (reg_wr && int'(reg_addr) == A_SWI)
            swi_ev = wlo & (~wlo + NLINES'(1));
    end

    always_comb begin
        strobe[CH_NORM] = reg_wr && int'(reg_addr) == A_CTRL && reg_wdata[0];
        strobe[CH_FAST] = reg_wr && int'(reg_addr) == A_CTRL && reg_wdata[1];
    end

    // Acknowledge-by-read of an edge source
    always_comb begin
        ack_clr = '0;
        if (reg_rd && int'(reg_addr) == A_NCODE)
            ack_clr = (NLINES'(1) << chan_code[CH_NORM]) & ~sens_q;
        else if (reg_rd && int'(reg_addr) == A_FCODE)
            ack_clr = (NLINES'(1) << chan_code[CH_FAST]) & ~sens_q;
    end

    intc_line_state #(.NLINES(NLINES), .PRIO_W(PRIO_W)) u_lines (
        .clk       (clk),
        .rst_n     (rst_n),
        .pins      (irq_lines[NLINES-1:0]),
        .cfg_we    (reg_wr && cfg_hit),
        .cfg_idx   (cfg_idx),
        .cfg_prio  (reg_wdata[CFG_PRIO_LSB +: PRIO_W]),
        .cfg_sens  (reg_wdata[CFG_SENS_BIT]),
        .cfg_steer (reg_wdata[CFG_STEER_BIT]),
        .mask_we   (reg_wr && int'(reg_addr) == A_MASK),
        .pend_we   (reg_wr && int'(reg_addr) == A_PEND),
        .wdata     (wlo),
        .swi_ev    (swi_ev),
        .ack_clr   (ack_clr),
        .pend_q    (pend_q),
        .mask_q    (mask_q),
        .sens_q    (sens_q),
        .steer_q   (steer_q),
        .prio_q    (prio_q)
    );

    always_comb begin
        chan_req[CH_NORM] = pend_q & ~mask_q & ~steer_q;
        chan_req[CH_FAST] = pend_q & ~mask_q & steer_q;
    end

    for (genvar c = 0; c < 2; c++) begin : g_chan
        intc_agree_fsm #(.NLINES(NLINES), .PRIO_W(PRIO_W)) u_fsm (
            .clk    (clk),
            .rst_n  (rst_n),
            .req    (chan_req[c]),
            .prio   (prio_q),
            .strobe (strobe[c]),
            .out    (chan_out[c]),
            .code   (chan_code[c])
        );
    end

    always_comb begin
        irq_out = chan_out[CH_NORM];
        fiq_out = chan_out[CH_FAST];
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_rd) begin
            if (cfg_hit)
                reg_rdata = DATA_W'({prio_q[cfg_idx], sens_q[cfg_idx], steer_q[cfg_idx]});
            else if (int'(reg_addr) == A_PEND)
                reg_rdata = DATA_W'(pend_q);
            else if (int'(reg_addr) == A_MASK)
                reg_rdata = DATA_W'(mask_q);
            else if (int'(reg_addr) == A_NCODE)
                reg_rdata = DATA_W'(chan_code[CH_NORM]);
            else if (int'(reg_addr) == A_FCODE)
                reg_rdata = DATA_W'(chan_code[CH_FAST]);
        end
    end

    AST_ONE_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ack_clr)); // R8
    AST_ONE_SWI: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(swi_ev)); // R9
    AST_CFG_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && cfg_hit) |-> (reg_rdata[DATA_W-1:CFG_W] == '0)); // R2

endmodule

// File: tb/edge_level_intc_test.sv
module edge_level_intc_test;

    localparam int PER = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] irq_lines;
    logic        reg_wr, reg_rd;
    logic [7:0]  reg_addr;
    logic [31:0] reg_wdata, reg_rdata;
    logic        irq_out, fiq_out;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(PER/2) clk = ~clk;

    edge_level_intc uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_lines (irq_lines),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq_out   (irq_out),
        .fiq_out   (fiq_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; irq_lines = '0; reg_wr = 1'b0; reg_rd = 1'b0;
        reg_addr = '0; reg_wdata = '0;
        wait_cyc(3);
        rst_n = 1'b1;
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic set_pins(input logic [31:0] v);
        @(negedge clk);
        irq_lines = v;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        do_reset();
        bus_read(8'h04, d); chk("R1 mask", d, 32'hFFFF_FFFF);
        bus_read(8'h00, d); chk("R1 pending", d, 32'h0);
        bus_read(8'h98, d); chk("R1 cfg31", d, 32'h0);
        chk("R1 outputs", {30'b0, irq_out, fiq_out}, 32'h0);
    endtask

    task automatic t_config();
        logic [31:0] d;
        do_reset();
        bus_write(8'h50, 32'h7F);
        bus_read(8'h50, d); chk("R2 cfg13 readback", d, 32'h7F);
        bus_write(8'h50, 32'hFFFF_FF35);
        bus_read(8'h50, d); chk("R2 cfg13 upper dropped", d, 32'h35);
        bus_read(8'h1C, d); chk("R2 cfg0 untouched", d, 32'h0);
    endtask

    task automatic t_edge();
        logic [31:0] d;
        do_reset();
        set_pins(32'h20); wait_cyc(2);
        bus_read(8'h00, d); chk("R3 edge set", d, 32'h20);
        set_pins(32'h0); wait_cyc(2);
        bus_read(8'h00, d); chk("R3 edge kept after drop", d, 32'h20);
        bus_write(8'h00, 32'h0);
        bus_read(8'h00, d); chk("R5 edge cleared by write", d, 32'h0);
        set_pins(32'h20); wait_cyc(2);
        bus_write(8'h00, 32'h0); wait_cyc(3);
        bus_read(8'h00, d); chk("R3 no retrigger while high", d, 32'h0);
    endtask

    task automatic t_level();
        logic [31:0] d;
        do_reset();
        bus_write(8'h38, 32'h2);               // line 7 level
        set_pins(32'h88); wait_cyc(2);
        bus_read(8'h00, d); chk("R4 level set", d, 32'h88);
        bus_write(8'h00, 32'h0);
        bus_read(8'h00, d); chk("R5 level high kept", d, 32'h80);
        bus_write(8'h04, ~32'h80); wait_cyc(3);
        chk("R11 unmask raises irq", {31'b0, irq_out}, 32'h1);
        bus_read(8'h10, d); chk("R8 level code", d, 32'd7);
        bus_read(8'h00, d); chk("R8 level not acked", d, 32'h80);
        set_pins(32'h08); wait_cyc(2);
        bus_read(8'h00, d); chk("R4 level drop clears", d, 32'h0);
    endtask

    task automatic t_arbitrate();
        logic [31:0] d;
        do_reset();
        bus_write(8'h24, 32'd12);              // line 2 prio 3
        bus_write(8'h40, 32'd4);               // line 9 prio 1
        bus_write(8'h6C, 32'd4);               // line 20 prio 1
        bus_write(8'h2C, 32'd1);               // line 4 prio 0, fast channel
        bus_write(8'h04, 32'h0);
        set_pins(32'h0010_0204); wait_cyc(3);
        chk("R7 irq raised", {31'b0, irq_out}, 32'h1);
        chk("R6 fast idle", {31'b0, fiq_out}, 32'h0);
        bus_read(8'h10, d); chk("R6 tie to highest line", d, 32'd20);
        bus_read(8'h00, d); chk("R8 edge acked", d, 32'h204);
        chk("R7 held after ack", {31'b0, irq_out}, 32'h1);
        bus_write(8'h18, 32'h1);
        chk("R7 strobe drops irq", {31'b0, irq_out}, 32'h0);
        wait_cyc(2);
        chk("R7 irq re-raised", {31'b0, irq_out}, 32'h1);
        bus_read(8'h10, d); chk("R6 next winner", d, 32'd9);
        bus_read(8'h18, d); chk("R7 control reads 0", d, 32'h0);
        set_pins(32'h0010_0214); wait_cyc(3);
        chk("R6 fast raised", {31'b0, fiq_out}, 32'h1);
        bus_read(8'h14, d); chk("R6 fast code", d, 32'd4);
    endtask

    task automatic t_mask();
        logic [31:0] d;
        do_reset();
        set_pins(32'h40); wait_cyc(3);
        chk("R11 masked no irq", {31'b0, irq_out}, 32'h0);
        bus_write(8'h04, ~32'h40); wait_cyc(2);
        chk("R11 unmask irq", {31'b0, irq_out}, 32'h1);
        bus_read(8'h10, d); chk("R11 code", d, 32'd6);
    endtask

    task automatic t_swi();
        logic [31:0] d;
        do_reset();
        bus_write(8'h9C, 32'h0000_0A00); wait_cyc(1);
        bus_read(8'h00, d); chk("R9 lowest bit only", d, 32'h200);
        bus_read(8'h9C, d); chk("R9 reads 0", d, 32'h0);
    endtask

    task automatic t_undef();
        logic [31:0] d;
        do_reset();
        bus_write(8'h0C, 32'hFFFF);
        bus_write(8'h10, 32'h0);
        bus_write(8'h14, 32'h0);
        bus_write(8'hA0, 32'h0);
        bus_write(8'h06, 32'h0);
        bus_read(8'h0C, d); chk("R10 undefined reads 0", d, 32'h0);
        bus_read(8'h04, d); chk("R10 mask untouched", d, 32'hFFFF_FFFF);
        bus_read(8'h10, d); chk("R10 code write ignored", d, 32'h0);
        bus_read(8'h00, d); chk("R10 pending untouched", d, 32'h0);
    endtask

    initial begin
        #(PER * 150000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; irq_lines = '0; reg_wr = 1'b0; reg_rd = 1'b0;
        reg_addr = '0; reg_wdata = '0;
        t_reset();
        t_config();
        t_edge();
        t_level();
        t_arbitrate();
        t_mask();
        t_swi();
        t_undef();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule